// File: doc/BRIEF.md
# Stored-Vector Pass/Fail Logic Tester

This block checks a small embedded circuit on its own, with no host attached. It holds a constant table of stimulus words and a matching table of expected responses. At a slow, human-visible pace it applies one stimulus at a time to the embedded circuit, a 4-bit magnitude comparator. It captures the circuit's response, compares it with the stored expected response and lights either a pass lamp or a fail lamp.

A run starts at the first table entry when reset is released. It steps through every entry once and then stops with a done indication. The last lamp state stays on until the next reset. A sticky flag records whether any entry failed during the run. A fault-inject input forces one response bit of the embedded circuit to 0, so that the detection path can be exercised.

Top module: `vec_tester`

## Requirements
- R1: While reset is held, and directly after it, pass_led, fail_led, any_fail and done are all 0.
- R2: An advance tick occurs once every DIV_RATIO clock cycles. Reset is synchronised internally over two cycles. The first lamp update therefore appears on the (DIV_RATIO+4)-th rising edge after rst_n is released, and each later update follows exactly DIV_RATIO cycles after the one before it.
- R3: Entry i (i = 0 .. NUM_VEC-1) of the stimulus table is the 8-bit word {A, B}, with A = i mod 16 in the upper nibble and B = 3*i mod 16 in the lower nibble. The entries are applied in order of increasing i.
- R4: For each stimulus, the embedded comparator returns a 3-bit response ordered {gt, eq, lt}. Exactly one bit is set. The expected response for entry i is the correct comparison of A and B.
- R5: After each compare, pass_led=1 and fail_led=0 when the captured response equals the expected response. The two lamps are never 1 at the same time.
- R6: After each compare, fail_led=1 and pass_led=0 when the captured response differs from the expected response.
- R7: done rises together with the lamp update for the last entry. From then on, the tester no longer advances, and done and both lamps hold their values until reset.
- R8: any_fail becomes 1 with the first fail_led update and stays 1 for the rest of the run, even when later entries pass. Only reset clears it.
- R9: When fault_inj is 1, the eq bit (bit 1) of the comparator response is forced to 0. With the default table, only entries 0 and 8 (where A equals B) then fail.
- R10: A reset restarts the run from entry 0 with all flags cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| fault_inj | input | 1 | Forces the comparator's eq output stuck at 0 |
| pass_led | output | 1 | Last compared entry matched |
| fail_led | output | 1 | Last compared entry mismatched |
| any_fail | output | 1 | At least one entry mismatched since reset |
| done | output | 1 | All entries have been checked |

## Verification
Each tick leads to three register stages: apply, capture and compare. A lamp result is due two cycles after the tick that applies its entry. The first result follows DIV_RATIO+4 edges after reset release, because the reset synchroniser and the divider's first count come before it. The bench counts edges from the release of reset. It checks that the lamps are still dark one edge before the first result is due. It then samples each entry's lamps, done and any_fail exactly DIV_RATIO edges apart, one time unit after the edge. After the last entry, it waits further periods to confirm that nothing moves.

// File: rtl/lt_pkg.sv
package lt_pkg;
  localparam int OPW  = 4;
  localparam int STW  = 2 * OPW;
  localparam int RSPW = 3;

  typedef logic [RSPW-1:0] rsp_t;  // {gt, eq, lt}

  localparam int RSP_EQ_BIT = 1;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_CAPT = 2'd1,
    PH_CMP  = 2'd2
  } phase_e;

  function automatic rsp_t cmp_golden(input logic [OPW-1:0] a, input logic [OPW-1:0] b);
    rsp_t r;
    r[2] = (a > b);
    r[1] = (a == b);
    r[0] = (a < b);
    return r;
  endfunction
endpackage

// File: rtl/lt_pacer.sv
module lt_pacer #(
  parameter int DIV_RATIO = 50_000_000
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int CW = (DIV_RATIO > 1) ? $clog2(DIV_RATIO) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV_RATIO - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    if (cnt_q == LAST) cnt_d = '0;
    else               cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign tick = (cnt_q == LAST);
endmodule

// File: rtl/lt_vec_rom.sv
module lt_vec_rom
  import lt_pkg::*;
#(
  parameter int NUM_VEC = 16,
  localparam int IW = (NUM_VEC > 1) ? $clog2(NUM_VEC) : 1
) (
  input  logic [IW-1:0]  idx,
  output logic [STW-1:0] stim,
  output rsp_t           resp
);
  function automatic logic [STW-1:0] stim_of(input int i);
    logic [OPW-1:0] a, b;
    a = OPW'(i % 16);
    b = OPW'((3 * i) % 16);
    return {a, b};
  endfunction

  logic [STW-1:0] stim_tab [NUM_VEC];
  rsp_t           resp_tab [NUM_VEC];

  for (genvar g = 0; g < NUM_VEC; g++) begin : g_tab
    assign stim_tab[g] = stim_of(g);
    assign resp_tab[g] = cmp_golden(stim_of(g)[STW-1:OPW], stim_of(g)[OPW-1:0]);
  end

  assign stim = stim_tab[idx];
  assign resp = resp_tab[idx];
endmodule

// File: rtl/lt_mag_cmp.sv
module lt_mag_cmp
  import lt_pkg::*;
(
  input  logic [OPW-1:0] a,
  input  logic [OPW-1:0] b,
  output rsp_t           res
);
  logic [OPW:0] diff;

  always_comb begin
    diff   = {1'b0, a} - {1'b0, b};
    res[1] = (diff == '0);
    res[0] = diff[OPW];
    res[2] = !diff[OPW] && (diff != '0);
  end
endmodule

// File: rtl/vec_tester.sv
module vec_tester
  import lt_pkg::*;
#(
  parameter int DIV_RATIO = 50_000_000,
  parameter int NUM_VEC   = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fault_inj,
  output logic pass_led,
  output logic fail_led,
  output logic any_fail,
  output logic done
);
  localparam int IW = (NUM_VEC > 1) ? $clog2(NUM_VEC) : 1;
  localparam logic [IW-1:0] LAST_IDX = IW'(NUM_VEC - 1);

  // reset synchroniser: asserts at once, releases after two edges
  logic rst_s1_q, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1_q   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_s1_q   <= 1'b1;
      rst_sync_n <= rst_s1_q;
    end
  end

  logic tick;
  lt_pacer #(.DIV_RATIO(DIV_RATIO)) u_pacer (
    .clk  (clk),
    .rst_n(rst_sync_n),
    .tick (tick)
  );

  logic [IW-1:0]  idx_q, idx_d;
  logic [STW-1:0] rom_stim;
  rsp_t           rom_resp;
  lt_vec_rom #(.NUM_VEC(NUM_VEC)) u_rom (
    .idx (idx_q),
    .stim(rom_stim),
    .resp(rom_resp)
  );

  logic [STW-1:0] stim_q, stim_d;
  rsp_t           dut_raw, dut_out;
  lt_mag_cmp u_dut (
    .a  (stim_q[STW-1:OPW]),
    .b  (stim_q[OPW-1:0]),
    .res(dut_raw)
  );

  always_comb begin
    dut_out = dut_raw;
    if (fault_inj) dut_out[RSP_EQ_BIT] = 1'b0;
  end

  phase_e ph_q, ph_d;
  rsp_t   cap_q, cap_d;
  logic   pass_q, pass_d, fail_q, fail_d, sticky_q, sticky_d, done_q, done_d;
  logic   match;

  assign match = (cap_q == rom_resp);

  always_comb begin
    ph_d     = ph_q;
    idx_d    = idx_q;
    stim_d   = stim_q;
    cap_d    = cap_q;
    pass_d   = pass_q;
    fail_d   = fail_q;
    sticky_d = sticky_q;
    done_d   = done_q;
    unique case (ph_q)
      PH_IDLE: begin
        if (tick && !done_q) begin
          stim_d = rom_stim;
          cap_d  = '0;
          ph_d   = PH_CAPT;
        end
      end
      PH_CAPT: begin
        cap_d = dut_out;
        ph_d  = PH_CMP;
      end
      PH_CMP: begin
        pass_d   = match;
        fail_d   = !match;
        sticky_d = sticky_q || !match;
        if (idx_q == LAST_IDX) done_d = 1'b1;
        else                   idx_d  = idx_q + 1'b1;
        ph_d = PH_IDLE;
      end
      default: ph_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      ph_q     <= PH_IDLE;
      idx_q    <= '0;
      stim_q   <= '0;
      cap_q    <= '0;
      pass_q   <= 1'b0;
      fail_q   <= 1'b0;
      sticky_q <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      ph_q     <= ph_d;
      idx_q    <= idx_d;
      stim_q   <= stim_d;
      cap_q    <= cap_d;
      pass_q   <= pass_d;
      fail_q   <= fail_d;
      sticky_q <= sticky_d;
      done_q   <= done_d;
    end
  end

  assign pass_led = pass_q;
  assign fail_led = fail_q;
  assign any_fail = sticky_q;
  assign done     = done_q;
endmodule

// File: rtl/lt_checker.sv
module lt_checker
  import lt_pkg::*;
(
  input logic clk,
  input logic rst_n,
  input logic pass_led,
  input logic fail_led,
  input logic any_fail,
  input logic done,
  input logic fault_inj,
  input rsp_t dut_out
);
  p_lamps_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(pass_led && fail_led));

  p_done_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (done && $stable(pass_led) && $stable(fail_led) && $stable(any_fail)));

  p_done_lit_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> (pass_led || fail_led));

  p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    any_fail |=> any_fail);

  p_fail_marks_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fail_led |-> any_fail);

  p_onehot_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !fault_inj |-> ($countones(dut_out) == 1));

  p_fault_eq_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fault_inj |-> !dut_out[RSP_EQ_BIT]);
endmodule

bind vec_tester lt_checker u_chk (
  .clk      (clk),
  .rst_n    (rst_sync_n),
  .pass_led (pass_led),
  .fail_led (fail_led),
  .any_fail (any_fail),
  .done     (done),
  .fault_inj(fault_inj),
  .dut_out  (dut_out)
);

// File: tb/tb_vec_tester.sv
`timescale 1ns/1ps
module tb_vec_tester;
  localparam int DIV = 4;
  localparam int NV  = 16;

  logic clk, rst_n, fault_inj;
  logic pass_led, fail_led, any_fail, done;
  int checks, errors;

  vec_tester #(.DIV_RATIO(DIV), .NUM_VEC(NV)) dut (
    .clk(clk), .rst_n(rst_n), .fault_inj(fault_inj),
    .pass_led(pass_led), .fail_led(fail_led), .any_fail(any_fail), .done(done)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic bit entry_fails(input int i, input bit flt);
    int a, b;
    a = i % 16;
    b = (3 * i) % 16;
    return flt && (a == b);
  endfunction

  task automatic do_reset(input bit flt);
    @(negedge clk);
    rst_n = 1'b0;
    fault_inj = flt;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic t_reset_state;
    @(negedge clk);
    rst_n = 1'b0;
    fault_inj = 1'b0;
    repeat (2) @(negedge clk);
    chk("R1", "pass_led in reset", pass_led, 0);
    chk("R1", "fail_led in reset", fail_led, 0);
    chk("R1", "any_fail in reset", any_fail, 0);
    chk("R1", "done in reset", done, 0);
  endtask

  // full run: checks timing, every entry's lamps, done, sticky flag
  task automatic t_run(input bit flt, input string tag);
    bit seen_fail;
    seen_fail = 1'b0;
    do_reset(flt);
    repeat (DIV + 3) @(posedge clk);
    #1;
    chk("R2", {tag, " lamps dark before first result"}, pass_led | fail_led, 0);
    chk("R1", {tag, " any_fail after reset"}, any_fail, 0);
    for (int k = 0; k < NV; k++) begin
      bit ef;
      if (k == 0) @(posedge clk);
      else repeat (DIV) @(posedge clk);
      #1;
      ef = entry_fails(k, flt);
      seen_fail |= ef;
      if (ef) begin
        chk("R6", $sformatf("%s entry %0d fail_led", tag, k), fail_led, 1);
        chk("R9", $sformatf("%s entry %0d pass_led", tag, k), pass_led, 0);
      end else begin
        chk("R5", $sformatf("%s entry %0d pass_led", tag, k), pass_led, 1);
        chk("R3", $sformatf("%s entry %0d fail_led", tag, k), fail_led, 0);
      end
      chk("R8", $sformatf("%s entry %0d any_fail", tag, k), any_fail, int'(seen_fail));
      chk("R7", $sformatf("%s entry %0d done", tag, k), done, (k == NV - 1) ? 1 : 0);
    end
  endtask

  task automatic t_clean;
    t_run(1'b0, "clean");
    chk("R4", "clean run no failure", any_fail, 0);
  endtask

  task automatic t_hold_after_done;
    bit p, f;
    p = pass_led;
    f = fail_led;
    repeat (5 * DIV) @(posedge clk);
    #1;
    chk("R7", "done held", done, 1);
    chk("R7", "pass_led held", pass_led, int'(p));
    chk("R7", "fail_led held", fail_led, int'(f));
  endtask

  task automatic t_fault;
    t_run(1'b1, "fault");
    chk("R9", "fault run any_fail", any_fail, 1);
    chk("R8", "final lamp pass after earlier fail", pass_led, 1);
  endtask

  task automatic t_restart;
    do_reset(1'b0);
    @(posedge clk);
    #1;
    chk("R10", "any_fail cleared by reset", any_fail, 0);
    chk("R10", "done cleared by reset", done, 0);
    repeat (DIV + 3) @(posedge clk);
    #1;
    chk("R10", "entry 0 passes after restart", pass_led, 1);
    chk("R10", "entry 0 not done", done, 0);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired: actual hung expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    checks = 0;
    errors = 0;
    rst_n = 1'b0;
    fault_inj = 1'b0;
    t_reset_state();
    t_clean();
    t_hold_after_done();
    t_fault();
    t_hold_after_done();
    t_restart();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule